// File: doc/BRIEF.md
# Sleep-Aware SAR ADC Conversion Sequencer

This block is the digital control unit for a successive-approximation analog-to-digital converter in a small microcontroller. The CPU reaches it through a byte-wide register port. It holds a control register with conversion-clock select, channel select, a start/done bit and an enable bit. It also holds a left-justified result split over a high and a low byte, and a one-bit completion flag with its interrupt enable. A conversion steps a trial code past an external comparator, most significant bit first. At the end the block clears the start/done bit, loads the result and raises the flag.

The block also watches the core's sleep state. With the internal RC oscillator selected as conversion clock, a started conversion runs on through sleep. The start is held back by one cycle, so the core can issue its sleep first. At completion the block either requests a wake-up, when the interrupt is enabled, or powers the converter down. With any divided system clock selected, entering sleep aborts the conversion and powers the converter down. Whenever the converter powers down, the enable bit stays set. The converter powers up again only when software next sets the start/done bit.

Register addresses on `addr_i`: 0 control, 1 result high byte, 2 result low byte, 3 flag register, 4 interrupt-enable register. Other addresses read as zero.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, every register reads 0x00 and `adc_on_o`, `irq_o` and `wake_o` are 0.
- R2: Control register (address 0) bit layout: [7:6] clock select, [5:3] channel bits 2..0, [2] start/done, [1] channel bit 3, [0] enable. Clock select 00/01/10 gives one step every DIV_A/DIV_B/DIV_C system cycles (defaults 2/8/32). 11 selects the RC oscillator, where one step happens per `rc_tick_i` pulse. `chan_o` presents the 4-bit channel.
- R3: A write to address 0 with start/done=1 and enable=0 starts nothing, and start/done reads back 0.
- R4: With a divided clock, a conversion lasts 10 steps, which is 20 system cycles at clock select 00. With the RC clock, stepping begins one cycle after the start is written.
- R5: On completion, start/done clears and the 10-bit result R is loaded: the high byte reads R[9:2] and the low byte reads {R[1:0], 6'b0}. Flag bit 0 at address 3 sets, and `irq_o` equals flag AND interrupt enable (bit 0 at address 4).
- R6: A conversion that completes while `sleep_i`=1 with the interrupt enable set drives `wake_o`=1, and the converter stays on.
- R7: A conversion that completes while `sleep_i`=1 with the interrupt enable clear turns the converter off (`adc_on_o`=0), and the enable bit still reads 1.
- R8: With a non-RC clock selected, `sleep_i`=1 aborts any conversion within one cycle and turns the converter off. Start/done reads 0, enable reads 1, and the flag is not set.
- R9: After a power-down, the converter stays off and no conversion starts until software writes start/done=1 with enable=1. That write turns `adc_on_o` back on.
- R10: Software can write flag bit 0 to clear it. Completion in the same cycle takes priority over the clear.
- R11: Each step tests the current trial bit of `trial_o` and keeps it when `comp_i`=1 and clears it when `comp_i`=0. It then sets the next lower bit. The first trial code is 10'h200.
- R12: Writing start/done=0 or enable=0 during a conversion aborts it without setting the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| sleep_i | input | 1 | Core is in sleep |
| rc_tick_i | input | 1 | One-cycle pulse per RC oscillator period |
| comp_i | input | 1 | Comparator: 1 when input is at or above the trial code |
| trial_o | output | 10 | Trial code driven to the DAC/comparator |
| chan_o | output | 4 | Selected analog channel |
| adc_on_o | output | 1 | Converter powered |
| irq_o | output | 1 | Completion interrupt request |
| wake_o | output | 1 | Wake-up request to the sleeping core |

## Verification
The bench targets the sleep boundary on both clock kinds. A design that aborted RC conversions on sleep would never raise `wake_o`. One that ignored sleep on a divided clock would go on to set the flag. One that cleared the enable bit on power-down would read back the wrong control value. It also holds sleep-induced power-down across the sleep exit. This catches a design that restarts on its own or stays powered. It also catches a start written with enable low that still begins converting. Conversions with inputs of 0, full scale, mid-scale and odd codes expose a wrong bit order, an off-by-one final step or a mis-packed result byte. A cycle-by-cycle reference model catches a missing or extra RC start delay and a wrong divider period.

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES_W = 10,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             sleep_i,
  input  logic             rc_tick_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [3:0]       chan_o,
  output logic             adc_on_o,
  output logic             irq_o,
  output logic             wake_o
);
  localparam int IW   = $clog2(RES_W);
  localparam int CW   = $clog2(DIV_C) + 1;
  localparam int PADW = 16 - RES_W;
  localparam logic [1:0] IDLE = 2'd0, HOLD = 2'd1, CONV = 2'd2;

  logic [1:0]       clk_sel, st;
  logic [3:0]       chan;
  logic             en, go, pwr_off, flag, ie;
  logic [RES_W-1:0] sar, res, sar_dec, sar_step;
  logic [IW-1:0]    idx;
  logic [CW-1:0]    cnt, div_top;
  logic [15:0]      res16;

  wire ctrl_wr   = wr_en_i && addr_i == 3'd0;
  wire flag_wr   = wr_en_i && addr_i == 3'd3;
  wire ie_wr     = wr_en_i && addr_i == 3'd4;
  wire rc_sel    = clk_sel == 2'b11;
  wire busy      = st != IDLE;
  wire sleep_kill = sleep_i && !rc_sel;
  wire start     = ctrl_wr && wdata_i[2] && wdata_i[0] && !busy;
  wire last      = idx == '0;

  always_comb begin
    case (clk_sel)
      2'b00:   div_top = CW'(DIV_A - 1);
      2'b01:   div_top = CW'(DIV_B - 1);
      default: div_top = CW'(DIV_C - 1);
    endcase
  end

  wire tick   = st == CONV && (rc_sel ? rc_tick_i : cnt == div_top);
  wire finish = tick && last && !sleep_kill;

  always_comb begin
    sar_dec = sar;
    if (!comp_i) sar_dec[idx] = 1'b0;
    sar_step = last ? sar_dec : (sar_dec | (RES_W'(1) << (idx - IW'(1))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel <= '0; chan <= '0; en <= 1'b0; go <= 1'b0;
      pwr_off <= 1'b0; flag <= 1'b0; ie <= 1'b0; st <= IDLE;
      sar <= '0; res <= '0; idx <= '0; cnt <= '0;
    end else begin
      if (st == HOLD) st <= CONV;
      if (st == CONV) cnt <= (cnt == div_top) ? '0 : cnt + CW'(1);
      if (ctrl_wr) begin
        clk_sel <= wdata_i[7:6];
        chan    <= {wdata_i[1], wdata_i[5:3]};
        en      <= wdata_i[0];
        if (!wdata_i[2] || !wdata_i[0]) begin
          go <= 1'b0;
          st <= IDLE;
        end
      end
      if (flag_wr) flag <= wdata_i[0];
      if (ie_wr)   ie   <= wdata_i[0];
      if (tick) begin
        sar <= sar_step;
        idx <= idx - IW'(1);
      end
      if (finish) begin
        res  <= sar_dec;
        go   <= 1'b0;
        st   <= IDLE;
        flag <= 1'b1;
        if (sleep_i && !ie) pwr_off <= 1'b1;
      end
      if (sleep_kill) begin
        pwr_off <= 1'b1;
        if (busy) begin
          go <= 1'b0;
          st <= IDLE;
        end
      end
      if (start) begin
        go      <= 1'b1;
        pwr_off <= 1'b0;
        st      <= (wdata_i[7:6] == 2'b11) ? HOLD : CONV;
        sar     <= RES_W'(1) << (RES_W - 1);
        idx     <= IW'(RES_W - 1);
        cnt     <= '0;
      end
    end
  end

  assign res16 = {res, {PADW{1'b0}}};

  always_comb begin
    case (addr_i)
      3'd0:    rdata_o = {clk_sel, chan[2:0], go, chan[3], en};
      3'd1:    rdata_o = res16[15:8];
      3'd2:    rdata_o = res16[7:0];
      3'd3:    rdata_o = {7'b0, flag};
      3'd4:    rdata_o = {7'b0, ie};
      default: rdata_o = 8'h00;
    endcase
  end

  assign trial_o  = sar;
  assign chan_o   = chan;
  assign adc_on_o = en && !pwr_off;
  assign irq_o    = flag && ie;
  assign wake_o   = sleep_i && flag && ie;

  a_r3_go_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> en);
  a_r4_rc_hold_one: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD && !ctrl_wr && !sleep_kill) |=> st == CONV);
  a_r5_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !ctrl_wr) |=> (!go && flag));
  a_r7_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && sleep_i && !ie && !ctrl_wr) |=> (!adc_on_o && en));
  a_r8_sleep_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sleep_kill && !ctrl_wr) |=> (!busy && !go && !adc_on_o && en == $past(en)));
  a_r9_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !ctrl_wr) |=> !go);
endmodule

// File: tb/adc_sar_seq_tb_top.sv
`timescale 1ns/1ps
module adc_sar_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, sleep = 1'b0, rc_tick = 1'b0, rc_run = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [9:0] trial;
  logic [3:0] chan;
  logic adc_on, irq, wake, comp;
  int vin = 0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  assign comp = vin >= int'(trial);

  adc_sar_seq dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .sleep_i(sleep), .rc_tick_i(rc_tick), .comp_i(comp),
    .trial_o(trial), .chan_o(chan), .adc_on_o(adc_on), .irq_o(irq), .wake_o(wake));

  int rc_cnt = 0;
  always @(negedge clk) begin
    if (rc_run) begin
      rc_cnt = rc_cnt + 1;
      rc_tick = (rc_cnt % 5) == 4;
    end else rc_tick = 1'b0;
  end

  // behavioural reference model
  int ms, mgo, mpoff, mclk, mchan, men, msar, midx, mcnt, mres, mflag, mie;
  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mgo = 0; mpoff = 0; mclk = 0; mchan = 0; men = 0;
      msar = 0; midx = 0; mcnt = 0; mres = 0; mflag = 0; mie = 0;
    end else begin
      int per, b, o_ms;
      bit rcs, tk, kill, strt, cmp, fin;
      cmp  = vin >= msar;
      per  = (mclk == 0) ? 2 : (mclk == 1) ? 8 : 32;
      rcs  = mclk == 3;
      tk   = (ms == 2) && (rcs ? rc_tick : (mcnt == per - 1));
      kill = sleep && !rcs;
      fin  = tk && midx == 0 && !kill;
      strt = wr_en && addr == 0 && wdata[2] && wdata[0] && ms == 0;
      o_ms = ms;
      if (o_ms == 1) ms = 2;
      if (o_ms == 2) mcnt = (mcnt == per - 1) ? 0 : mcnt + 1;
      if (wr_en && addr == 0) begin
        mclk = wdata[7:6]; mchan = {wdata[1], wdata[5:3]}; men = wdata[0];
        if (!wdata[2] || !wdata[0]) begin mgo = 0; ms = 0; end
      end
      if (wr_en && addr == 3) mflag = wdata[0];
      if (wr_en && addr == 4) mie = wdata[0];
      if (tk) begin
        b = 1 << midx;
        if (!cmp) msar = msar & ~b;
        if (fin) begin
          mres = msar; mgo = 0; ms = 0; mflag = 1;
          if (sleep && !mie) mpoff = 1;
        end
        if (midx > 0) msar = msar | (b >> 1);
        midx = midx - 1;
      end
      if (kill) begin
        mpoff = 1;
        if (o_ms != 0) begin mgo = 0; ms = 0; end
      end
      if (strt) begin
        mgo = 1; mpoff = 0; ms = (wdata[7:6] == 3) ? 1 : 2;
        msar = 512; midx = 9; mcnt = 0;
      end
    end
  end

  function automatic int mread(input int a);
    case (a)
      0: return (mclk << 6) | ((mchan & 7) << 3) | (mgo << 2) | (((mchan >> 3) & 1) << 1) | men;
      1: return mres >> 2;
      2: return (mres & 3) << 6;
      3: return mflag;
      4: return mie;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2 model rdata", int'(rdata), mread(int'(addr)));
      chk("R7 model adc_on", int'(adc_on), int'(men && !mpoff));
      chk("R5 model irq", int'(irq), int'(mflag && mie));
      chk("R6 model wake", int'(wake), int'(sleep && mflag && mie));
      chk("R11 model trial", int'(trial), msar);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 3'(a); #1; v = int'(rdata);
  endtask

  task automatic wait_go_low(output int cyc);
    int v;
    cyc = 0;
    rd(0, v);
    while (v[2] && cyc < 3000) begin cyc++; rd(0, v); end
  endtask

  task automatic convert(input int clks, input int ch, input int v, input string tag);
    int c, h, l;
    vin = v;
    wr(0, (clks << 6) | ((ch & 7) << 3) | 4 | (((ch >> 3) & 1) << 1) | 1);
    wait_go_low(c);
    rd(1, h); rd(2, l);
    chk({tag, " result high"}, h, v >> 2);
    chk({tag, " result low"}, l, (v & 3) << 6);
    chk("R2 chan_o", int'(chan), ch);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1 reset reg", v, 0); end
    chk("R1 reset adc_on", int'(adc_on), 0);
    chk("R1 reset irq", int'(irq), 0);

    wr(0, 8'h04);
    rd(0, v); chk("R3 go without enable", v, 0);
    repeat (30) @(negedge clk);
    rd(3, v); chk("R3 no flag", v, 0);

    vin = 700;
    wr(0, 8'h05);
    wait_go_low(c); chk("R4 div-2 step count", c + 1, 20);
    rd(3, v); chk("R5 flag set", v, 1);
    wr(3, 0); rd(3, v); chk("R10 flag cleared", v, 0);

    wr(4, 1);
    convert(0, 9, 0, "R11 zero");
    chk("R5 irq", int'(irq), 1);
    convert(1, 3, 1023, "R11 full");
    convert(2, 12, 512, "R11 mid");
    convert(1, 5, 341, "R11 odd");
    rc_run = 1'b1;
    convert(3, 7, 682, "R4 rc");

    // R6: RC conversion through sleep with interrupt enabled
    wr(3, 0); vin = 123;
    wr(0, 8'hC5);
    sleep = 1'b1;
    wait_go_low(c);
    @(negedge clk); #1;
    chk("R6 wake", int'(wake), 1);
    chk("R6 stays on", int'(adc_on), 1);
    sleep = 1'b0;
    rd(1, v); chk("R6 result", v, 123 >> 2);

    // R7: RC conversion through sleep, interrupt disabled
    wr(4, 0); wr(3, 0); vin = 900;
    wr(0, 8'hC5);
    sleep = 1'b1;
    wait_go_low(c);
    @(negedge clk); #1;
    chk("R7 off", int'(adc_on), 0);
    chk("R7 no wake", int'(wake), 0);
    rd(0, v); chk("R7 enable kept", v, 8'hC1);
    sleep = 1'b0;
    repeat (40) @(negedge clk);
    rd(0, v); chk("R9 no self restart", v & 4, 0);
    chk("R9 still off", int'(adc_on), 0);
    wr(0, 8'hC5);
    #1; chk("R9 powered on by start", int'(adc_on), 1);
    wait_go_low(c);

    // R8: divided clock, sleep aborts
    wr(3, 0); vin = 400;
    wr(0, 8'h85);
    repeat (10) @(negedge clk);
    sleep = 1'b1;
    repeat (2) @(negedge clk); #1;
    chk("R8 off", int'(adc_on), 0);
    rd(0, v); chk("R8 go clear enable kept", v, 8'h81);
    rd(3, v); chk("R8 no flag", v, 0);
    sleep = 1'b0;
    repeat (20) @(negedge clk);
    rd(0, v); chk("R9 no restart after abort", v & 4, 0);

    // R12: software abort
    wr(0, 8'h45);
    repeat (12) @(negedge clk);
    wr(0, 8'h41);
    repeat (100) @(negedge clk);
    rd(3, v); chk("R12 abort no flag", v, 0);
    rd(0, v); chk("R12 go cleared", v, 8'h41);
    wr(0, 8'h45);
    repeat (5) @(negedge clk);
    wr(0, 8'h44);
    rd(0, v); chk("R12 disable aborts", v, 8'h40);
    repeat (100) @(negedge clk);
    rd(3, v); chk("R12 disable no flag", v, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule